// File: doc/BRIEF.md
# Three-Player Quiz Buzzer Controller

This block holds the game state of a quiz round with three contestants. A host start pulse opens a round. It reloads a seconds countdown, clears the previous winner and opens the buzzers. The first contestant key seen while the round is open is latched as the winner. That press also closes the round, which freezes the countdown at the second it had reached. If nobody buzzes before the countdown reaches zero, the round closes on its own.

While a winner is latched, host plus and minus pulses raise or lower that contestant's score. Scores live across rounds and go back to their initial value only on reset. All inputs are taken to be debounced single-cycle pulses that are synchronous to the clock.

A prescaler of `TICK_CYCLES` clock cycles produces the one-second tick. The round length, score width and initial score are also parameters.

Top module: `quiz_buzzer_ctrl`

## Requirements
- R1: While `rst_i` is high at a clock edge, all three scores load `SCORE_INIT` (10), `secs_o` loads `ROUND_SECS` (30), the prescaler clears, `locked_o` goes low and `winner_o` goes to 000. The countdown then runs as if a start had been given.
- R2: A `start_i` pulse reloads `secs_o` to `ROUND_SECS`, restarts the prescaler and clears `locked_o` and `winner_o` at that edge. Each decrement of `secs_o` by one comes exactly `TICK_CYCLES` cycles after the previous decrement or after the start.
- R3: `key_i` is one-hot: bit 0 is player 1, bit 1 is player 2 and bit 2 is player 3. A nonzero `key_i` while `locked_o` is low and `start_i` is low sets the matching bit of `winner_o` and raises `locked_o`, both at the next edge.
- R4: While `locked_o` is high and no start arrives, `secs_o` and `winner_o` hold their values.
- R5: A key press while `locked_o` is high has no effect on `winner_o`. This covers a slower second contestant and any press after a timeout.
- R6: At the edge where the countdown steps from 1 to 0 with no buzz, `locked_o` goes high, and `winner_o` stays 000.
- R7: If several key bits are high in the same open cycle, only the lowest-numbered player is latched. `winner_o` never has more than one bit set.
- R8: `plus_i` adds 1 to, and `minus_i` subtracts 1 from, the score of the player in `winner_o` as it stands at that edge. The pulse has no effect when `winner_o` is 000, and the scores are unchanged when both pulses come in the same cycle.
- R9: Scores are `SCORE_W`-bit unsigned values (5 bits by default). They saturate at 0 and at 2^`SCORE_W`-1 (31).
- R10: `start_i` never changes any score.
- R11: A key press in the same cycle as `start_i` is ignored, and the round opens with no winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous reset, active high |
| start_i | input | 1 | host start pulse |
| plus_i | input | 1 | host score increment pulse |
| minus_i | input | 1 | host score decrement pulse |
| key_i | input | 3 | contestant keys, one bit per player |
| secs_o | output | $clog2(ROUND_SECS+1) | seconds remaining |
| locked_o | output | 1 | round closed by a buzz or a timeout |
| winner_o | output | 3 | latched winner, one-hot |
| score1_o | output | SCORE_W | player 1 score |
| score2_o | output | SCORE_W | player 2 score |
| score3_o | output | SCORE_W | player 3 score |

## Verification
The bench builds the block with `TICK_CYCLES` = 4 and `ROUND_SECS` = 5, so a full timeout round lasts only twenty cycles. This lets the bench run timeouts, frozen countdowns and exact tick spacing many times over. `SCORE_W` keeps its default of 5 with an initial score of 10. Reaching the upper bound takes 21 plus pulses and reaching zero takes 31 minus pulses, so the bench can drive both saturation edges within one run.

// File: rtl/quiz_buzzer_ctrl.sv
module quiz_buzzer_ctrl #(
  parameter int TICK_CYCLES = 50_000_000,
  parameter int ROUND_SECS  = 30,
  parameter int SCORE_W     = 5,
  parameter int SCORE_INIT  = 10,
  localparam int SW = $clog2(ROUND_SECS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               start_i,
  input  logic               plus_i,
  input  logic               minus_i,
  input  logic [2:0]         key_i,
  output logic [SW-1:0]      secs_o,
  output logic               locked_o,
  output logic [2:0]         winner_o,
  output logic [SCORE_W-1:0] score1_o,
  output logic [SCORE_W-1:0] score2_o,
  output logic [SCORE_W-1:0] score3_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [SCORE_W-1:0] SMAX = {SCORE_W{1'b1}};

  logic [PW-1:0]      presc_q;
  logic [SW-1:0]      secs_q;
  logic               lock_q;
  logic [2:0]         win_q;
  logic [SCORE_W-1:0] score_q [3];

  wire       tick   = presc_q == PW'(TICK_CYCLES - 1);
  wire [2:0] first  = key_i & (~key_i + 3'd1);
  wire       has_w  = |win_q;
  wire       adj_up = plus_i & ~minus_i & has_w;
  wire       adj_dn = minus_i & ~plus_i & has_w;

  always_ff @(posedge clk_i) begin
    if (rst_i || start_i) begin
      presc_q <= '0;
      secs_q  <= SW'(ROUND_SECS);
      lock_q  <= 1'b0;
      win_q   <= 3'b000;
    end else if (!lock_q) begin
      if (key_i != 3'b000) begin
        win_q  <= first;
        lock_q <= 1'b1;
      end else if (tick) begin
        presc_q <= '0;
        secs_q  <= secs_q - 1'b1;
        if (secs_q == SW'(1)) lock_q <= 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_score
    always_ff @(posedge clk_i) begin
      if (rst_i)
        score_q[g] <= SCORE_W'(SCORE_INIT);
      else if (win_q[g] && adj_up && score_q[g] != SMAX)
        score_q[g] <= score_q[g] + 1'b1;
      else if (win_q[g] && adj_dn && score_q[g] != '0)
        score_q[g] <= score_q[g] - 1'b1;
    end
  end

  assign secs_o   = secs_q;
  assign locked_o = lock_q;
  assign winner_o = win_q;
  assign score1_o = score_q[0];
  assign score2_o = score_q[1];
  assign score3_o = score_q[2];
endmodule

// File: rtl/quiz_buzzer_ctrl_chk.sv
module quiz_buzzer_ctrl_chk #(
  parameter int ROUND_SECS = 30,
  parameter int SCORE_W    = 5,
  parameter int SW         = 5
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               start_i,
  input logic               plus_i,
  input logic               minus_i,
  input logic [2:0]         key_i,
  input logic [SW-1:0]      secs_o,
  input logic               locked_o,
  input logic [2:0]         winner_o,
  input logic [SCORE_W-1:0] score1_o,
  input logic [SCORE_W-1:0] score2_o,
  input logic [SCORE_W-1:0] score3_o
);
  logic seen = 1'b0;
  always_ff @(posedge clk_i) seen <= seen | rst_i;

  a_r7_single_winner: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    $onehot0(winner_o));

  a_r4_freeze: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    locked_o && !start_i |=> $stable(secs_o) && $stable(winner_o) && locked_o);

  a_r6_zero_locks: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    secs_o == '0 |-> locked_o);

  a_r2_start_opens: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    start_i |=> !locked_o && winner_o == 3'b000 && secs_o == SW'(ROUND_SECS));

  a_r3_buzz_latch: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    !locked_o && !start_i && key_i != 3'b000 |=> locked_o && winner_o != 3'b000);

  a_r10_start_keeps_scores: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    start_i && !plus_i && !minus_i |=> $stable(score1_o) && $stable(score2_o) && $stable(score3_o));

  a_r8_no_winner_no_change: assert property (@(posedge clk_i) disable iff (rst_i || !seen)
    winner_o == 3'b000 |=> $stable(score1_o) && $stable(score2_o) && $stable(score3_o));
endmodule

bind quiz_buzzer_ctrl quiz_buzzer_ctrl_chk #(
  .ROUND_SECS(ROUND_SECS), .SCORE_W(SCORE_W), .SW(SW)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .plus_i(plus_i),
  .minus_i(minus_i), .key_i(key_i), .secs_o(secs_o), .locked_o(locked_o),
  .winner_o(winner_o), .score1_o(score1_o), .score2_o(score2_o), .score3_o(score3_o)
);

// File: tb/quiz_buzzer_ctrl_tb_top.sv
`timescale 1ns/1ps
module quiz_buzzer_ctrl_tb_top;
  localparam int TICK = 4;
  localparam int RS   = 5;
  localparam int SW   = $clog2(RS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, plus = 1'b0, minus = 1'b0;
  logic [2:0] key = 3'b000;
  logic [SW-1:0] secs;
  logic locked;
  logic [2:0] winner;
  logic [4:0] s1, s2, s3;

  always #2 clk = ~clk;

  quiz_buzzer_ctrl #(.TICK_CYCLES(TICK), .ROUND_SECS(RS), .SCORE_W(5), .SCORE_INIT(10)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .plus_i(plus), .minus_i(minus),
    .key_i(key), .secs_o(secs), .locked_o(locked), .winner_o(winner),
    .score1_o(s1), .score2_o(s2), .score3_o(s3));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0, live = 0;

  int m_secs, m_presc, m_lock, m_win;
  int m_sc[3];

  always @(posedge clk) begin
    if (rst) begin
      m_secs = RS; m_presc = 0; m_lock = 0; m_win = 0;
      for (int i = 0; i < 3; i++) m_sc[i] = 10;
      live = 1;
    end else begin
      for (int i = 0; i < 3; i++)
        if (m_win == (1 << i)) begin
          if (plus && !minus && m_sc[i] < 31) m_sc[i]++;
          else if (minus && !plus && m_sc[i] > 0) m_sc[i]--;
        end
      if (start) begin
        m_secs = RS; m_presc = 0; m_lock = 0; m_win = 0;
      end else if (m_lock == 0) begin
        if (key != 0) begin
          for (int i = 2; i >= 0; i--) if (key[i]) m_win = 1 << i;
          m_lock = 1;
        end else if (m_presc == TICK - 1) begin
          m_presc = 0;
          m_secs--;
          if (m_secs == 0) m_lock = 1;
        end else m_presc++;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R1 R2 R4 R6 secs", int'(secs), m_secs);
      chk("R6 lock", int'(locked), m_lock);
      chk("R3 R5 R7 R11 winner", int'(winner), m_win);
      chk("R8 R9 R10 score1", int'(s1), m_sc[0]);
      chk("R8 R9 R10 score2", int'(s2), m_sc[1]);
      chk("R8 R9 R10 score3", int'(s3), m_sc[2]);
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      report();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic st, logic pl, logic mi, logic [2:0] k);
    @(negedge clk);
    start = st; plus = pl; minus = mi; key = k;
    @(negedge clk);
    start = 0; plus = 0; minus = 0; key = 0;
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    chk("R1 reset score", int'(s2), 10);
    chk("R1 reset secs", int'(secs), RS);
    chk("R1 reset lock", int'(locked), 0);
    cyc(8);
    pulse(0, 0, 0, 3'b001);
    chk("R3 winner p1", int'(winner), 1);
    chk("R3 locked", int'(locked), 1);
    pulse(0, 0, 0, 3'b010);
    chk("R5 late press", int'(winner), 1);
    cyc(12);
    chk("R4 frozen secs", int'(secs), RS - 2);
    pulse(0, 1, 0, 3'b000);
    chk("R8 plus winner", int'(s1), 11);
    pulse(0, 1, 1, 3'b000);
    chk("R8 both pulses", int'(s1), 11);
    pulse(1, 0, 0, 3'b000);
    chk("R2 reload", int'(secs), RS);
    chk("R10 score kept", int'(s1), 11);
    cyc(3);
    chk("R2 before tick", int'(secs), RS);
    cyc(1);
    chk("R2 first tick", int'(secs), RS - 1);
    pulse(0, 1, 0, 3'b000);
    chk("R8 no winner", int'(s1) + int'(s2) + int'(s3), 31);
    pulse(0, 0, 0, 3'b110);
    chk("R7 lowest wins", int'(winner), 2);
    pulse(0, 0, 1, 3'b000);
    chk("R8 minus p2", int'(s2), 9);
    pulse(1, 0, 0, 3'b000);
    cyc(22);
    chk("R6 timeout lock", int'(locked), 1);
    chk("R6 timeout secs", int'(secs), 0);
    pulse(0, 0, 0, 3'b100);
    chk("R5 after timeout", int'(winner), 0);
    pulse(1, 0, 0, 3'b100);
    chk("R11 start with key", int'(winner), 0);
    chk("R11 open", int'(locked), 0);
    pulse(0, 0, 0, 3'b100);
    for (int i = 0; i < 25; i++) pulse(0, 1, 0, 3'b000);
    chk("R9 upper bound", int'(s3), 31);
    for (int i = 0; i < 35; i++) pulse(0, 0, 1, 3'b000);
    chk("R9 lower bound", int'(s3), 0);
    @(negedge clk) rst = 1;
    cyc(2);
    rst = 0;
    cyc(1);
    chk("R1 scores back", int'(s3), 10);
    cyc(30);
    report();
  end
endmodule